// File: doc/BRIEF.md
# Write-Gathering Line Buffer

This block sits between a processor store port and a 64-bit memory bus for address regions that hardware only writes, such as frame buffers or streaming devices. Word stores that walk through a line in ascending order are merged into a single line buffer. When the store to the line's final word lands, the whole line leaves as one burst. The buffer is also pushed out early for five reasons: a store to a different line, a sync request, a prefetch-nudge hint, an exception, or a load that targets the buffered line. A line that is incomplete at that moment is written as separate single-beat writes that carry only the words that were stored.

Loads to the region are never answered from the buffer. The block only holds a load whose line is buffered until that line has reached the bus. The load itself travels on an uncached path outside this block. Stores that are narrower than a word, or that arrive out of order within a line, are outside the contract and give undefined results. The write-out is driven by a four-state machine:

- `S_EMPTY`: nothing is held.
- `S_GATHER`: a line is being filled.
- `S_BURST`: a complete line is being sent.
- `S_PARTIAL`: beats of an incomplete line are being sent one at a time.

The transitions are:

- **start**: `S_EMPTY` to `S_GATHER` on a store to any word except the last.
- **close-full**: `S_EMPTY` or `S_GATHER` to `S_BURST` when the last-word store completes the mask, or when a flush cause arrives with a full mask.
- **close-partial**: `S_EMPTY` or `S_GATHER` to `S_PARTIAL` on a last-word store with an incomplete mask, or on a flush cause while the line is incomplete.
- **drain**: `S_BURST` or `S_PARTIAL` back to `S_EMPTY` after the final beat position has been handled.

Top module: `sgu_top`

## Requirements
- R1: After reset, `bus_valid` is 0, `st_ready` is 1 and `ld_ready` is 1.
- R2: Stores to words other than the last one only fill the buffer and cause no bus activity. Store address bits [4:2] select the word, and bits [31:5] are the line tag.
- R3: A store to word 7 that completes the line starts a burst of 4 beats. Every beat has `bus_addr` equal to the line base, `bus_len` = 3 and `bus_strb` = 8'hFF. `bus_last` is set only on the fourth beat. Beat b carries word 2b in bits [31:0] and word 2b+1 in bits [63:32].
- R4: While a line is gathering, a store to a different line is stalled (`st_ready` = 0) until the held line has been written out. The store is then accepted as the first word of the new line.
- R5: A one-cycle pulse on `sync_req`, `nudge_req` or `exc_req` pushes out a non-empty buffer. When the buffer is empty, such a pulse causes no bus activity.
- R6: A load whose line tag matches the held line has `ld_ready` low and starts a flush. `ld_ready` returns to 1 only after the last beat of that line has been accepted. A load to any other line sees `ld_ready` = 1 and starts no flush.
- R7: An incomplete line is written beat position by beat position in ascending order. Each written beat has `bus_len` = 0, `bus_last` = 1 and `bus_addr` = line base + 8·b. A beat with both words stored uses strobe 8'hFF. A beat with only the even word uses 8'h0F, and a beat with only the odd word uses 8'hF0. Unstored lanes carry zero data. Beat positions with no stored word produce no write.
- R8: While `bus_valid` is high and `bus_ready` is low, the bus address, data, strobes and last flag stay unchanged. `st_ready` is 0 whenever `bus_valid` is high.
- R9: A store to word 7 into an empty buffer is written out immediately as a single odd-word write with strobe 8'hF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted when high with st_valid |
| st_addr | input | ADDR_W | Store byte address (word aligned) |
| st_data | input | 32 | Store word |
| ld_valid | input | 1 | Load request to the region |
| ld_addr | input | ADDR_W | Load byte address |
| ld_ready | output | 1 | Low while the load's line is still held |
| sync_req | input | 1 | Sync flush request |
| nudge_req | input | 1 | Prefetch-nudge flush hint |
| exc_req | input | 1 | Exception flush request |
| bus_valid | output | 1 | Bus write beat valid |
| bus_ready | input | 1 | Bus accepts the beat |
| bus_addr | output | ADDR_W | Write address |
| bus_data | output | 64 | Write data |
| bus_strb | output | 8 | Byte strobes |
| bus_len | output | BIDX_W | Beats in transaction minus one |
| bus_last | output | 1 | Final beat of transaction |

## Verification
Suppose a store that completes a line, or a flush pulse, is taken at a rising edge. Then the first beat is presented right after that same edge and can be accepted at the next edge. After that, one beat is accepted per edge while `bus_ready` stays high. `st_ready` and `ld_ready` are combinational, so they are judged in the same cycle the request is presented.

The bench predicts every beat into a queue before it drives the stimulus. A monitor running on the falling edge pops and compares each accepted beat, so stalls inserted through `bus_ready` shift when beats appear but not what they contain. After each scenario the bench lets the bus drain and confirms that nothing is left in the queue and that no unexpected beat appeared.

// File: rtl/sgu_pkg.sv
package sgu_pkg;
    localparam int WORD_W = 32;
    localparam int BUS_W  = 64;
    localparam int LANES  = BUS_W / WORD_W;

    typedef enum logic [1:0] {
        S_EMPTY,
        S_GATHER,
        S_BURST,
        S_PARTIAL
    } sgu_state_e;
endpackage

// File: rtl/sgu_line_buf.sv
module sgu_line_buf
    import sgu_pkg::*;
#(
    parameter int LINE_WORDS = 8,
    parameter int TAG_W      = 27,
    localparam int WIDX_W    = $clog2(LINE_WORDS),
    localparam int BEATS     = LINE_WORDS / LANES,
    localparam int BIDX_W    = $clog2(BEATS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  start_line,
    input  logic [TAG_W-1:0]      wr_tag,
    input  logic [WIDX_W-1:0]     wr_idx,
    input  logic [WORD_W-1:0]     wr_data,
    input  logic                  clear,
    input  logic [BIDX_W-1:0]     beat_sel,
    output logic [LINE_WORDS-1:0] mask,
    output logic [TAG_W-1:0]      tag,
    output logic [BUS_W-1:0]      beat_data,
    output logic [LANES-1:0]      beat_mask
);
    logic [WORD_W-1:0] word_q [LINE_WORDS];

    for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == WIDX_W'(w)) begin
                word_q[w] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            mask <= '0;
        end else if (wr_en) begin
            mask <= (start_line ? '0 : mask) | (LINE_WORDS'(1) << wr_idx);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag <= '0;
        end else if (wr_en && start_line) begin
            tag <= wr_tag;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign beat_data[l*WORD_W +: WORD_W] = word_q[WIDX_W'(LANES * beat_sel + l)];
    end
    assign beat_mask = mask[beat_sel*LANES +: LANES];
endmodule

// File: rtl/sgu_beat_fmt.sv
module sgu_beat_fmt
    import sgu_pkg::*;
(
    input  logic               full_line,
    input  logic [BUS_W-1:0]   raw_data,
    input  logic [LANES-1:0]   lane_valid,
    output logic [BUS_W-1:0]   out_data,
    output logic [BUS_W/8-1:0] out_strb
);
    localparam int LANE_BYTES = WORD_W / 8;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic live;
        assign live = full_line || lane_valid[l];
        assign out_strb[l*LANE_BYTES +: LANE_BYTES] = {LANE_BYTES{live}};
        assign out_data[l*WORD_W +: WORD_W] = live ? raw_data[l*WORD_W +: WORD_W] : '0;
    end
endmodule

// File: rtl/sgu_top.sv
module sgu_top
    import sgu_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_WORDS = 8,
    localparam int BEATS     = LINE_WORDS / LANES,
    localparam int OFF_W     = $clog2(LINE_WORDS * (WORD_W / 8)),
    localparam int TAG_W     = ADDR_W - OFF_W,
    localparam int WIDX_W    = $clog2(LINE_WORDS),
    localparam int BIDX_W    = $clog2(BEATS),
    localparam int BOFF_W    = $clog2(BUS_W / 8)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 st_valid,
    output logic                 st_ready,
    input  logic [ADDR_W-1:0]    st_addr,
    input  logic [WORD_W-1:0]    st_data,
    input  logic                 ld_valid,
    input  logic [ADDR_W-1:0]    ld_addr,
    output logic                 ld_ready,
    input  logic                 sync_req,
    input  logic                 nudge_req,
    input  logic                 exc_req,
    output logic                 bus_valid,
    input  logic                 bus_ready,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [BUS_W-1:0]     bus_data,
    output logic [BUS_W/8-1:0]   bus_strb,
    output logic [BIDX_W-1:0]    bus_len,
    output logic                 bus_last
);
    sgu_state_e state, state_nx;

    logic [BIDX_W-1:0]     beat_ctr;
    logic [LINE_WORDS-1:0] mask;
    logic [TAG_W-1:0]      buf_tag;
    logic [BUS_W-1:0]      raw_beat;
    logic [LANES-1:0]      beat_mask;
    logic [BUS_W-1:0]      fmt_data;
    logic [BUS_W/8-1:0]    fmt_strb;

    logic [TAG_W-1:0]      st_tag, ld_tag;
    logic [WIDX_W-1:0]     st_idx;
    logic [LINE_WORDS-1:0] mask_after;
    logic occupied, ld_hit, st_miss, flush_cause;
    logic st_fire, last_store, beat_has, beat_done, end_flush;
    logic unused_addr_bits;

    assign st_tag   = st_addr[ADDR_W-1:OFF_W];
    assign st_idx   = st_addr[OFF_W-1:2];
    assign ld_tag   = ld_addr[ADDR_W-1:OFF_W];
    assign unused_addr_bits = ^{st_addr[1:0], ld_addr[OFF_W-1:0]};

    assign occupied    = (state != S_EMPTY);
    assign ld_hit      = ld_valid && occupied && (ld_tag == buf_tag);
    assign st_miss     = st_valid && (state == S_GATHER) && (st_tag != buf_tag);
    assign flush_cause = (state == S_GATHER) &&
                         (sync_req || nudge_req || exc_req || ld_hit || st_miss);

    assign st_ready   = (state == S_EMPTY) || ((state == S_GATHER) && !flush_cause);
    assign ld_ready   = !(occupied && (ld_tag == buf_tag));
    assign st_fire    = st_valid && st_ready;
    assign last_store = st_fire && (st_idx == WIDX_W'(LINE_WORDS - 1));
    assign mask_after = ((state == S_EMPTY) ? '0 : mask) | (LINE_WORDS'(1) << st_idx);

    assign beat_has  = |beat_mask;
    assign beat_done = ((state == S_BURST) && bus_ready) ||
                       ((state == S_PARTIAL) && (!beat_has || bus_ready));
    assign end_flush = beat_done && (beat_ctr == BIDX_W'(BEATS - 1));

    sgu_line_buf #(.LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (st_fire),
        .start_line(state == S_EMPTY),
        .wr_tag    (st_tag),
        .wr_idx    (st_idx),
        .wr_data   (st_data),
        .clear     (end_flush),
        .beat_sel  (beat_ctr),
        .mask      (mask),
        .tag       (buf_tag),
        .beat_data (raw_beat),
        .beat_mask (beat_mask)
    );

    sgu_beat_fmt u_fmt (
        .full_line (state == S_BURST),
        .raw_data  (raw_beat),
        .lane_valid(beat_mask),
        .out_data  (fmt_data),
        .out_strb  (fmt_strb)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            S_EMPTY: begin
                if (last_store)   state_nx = (&mask_after) ? S_BURST : S_PARTIAL;
                else if (st_fire) state_nx = S_GATHER;
            end
            S_GATHER: begin
                if (flush_cause)     state_nx = (&mask) ? S_BURST : S_PARTIAL;
                else if (last_store) state_nx = (&mask_after) ? S_BURST : S_PARTIAL;
            end
            S_BURST, S_PARTIAL: begin
                if (end_flush) state_nx = S_EMPTY;
            end
            default: state_nx = S_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_EMPTY;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || end_flush) beat_ctr <= '0;
        else if (beat_done)      beat_ctr <= beat_ctr + 1'b1;
    end

    always_comb begin
        bus_valid = 1'b0;
        bus_addr  = {buf_tag, {OFF_W{1'b0}}};
        bus_len   = '0;
        bus_last  = 1'b1;
        bus_data  = fmt_data;
        bus_strb  = fmt_strb;
        unique case (state)
            S_BURST: begin
                bus_valid = 1'b1;
                bus_len   = BIDX_W'(BEATS - 1);
                bus_last  = (beat_ctr == BIDX_W'(BEATS - 1));
            end
            S_PARTIAL: begin
                bus_valid = beat_has;
                bus_addr  = {buf_tag, beat_ctr, {BOFF_W{1'b0}}};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sgu_checks.sv
module sgu_checks #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int BIDX_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              st_ready,
    input logic              ld_valid,
    input logic [ADDR_W-1:0] ld_addr,
    input logic              ld_ready,
    input logic              bus_valid,
    input logic              bus_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [63:0]       bus_data,
    input logic [7:0]        bus_strb,
    input logic [BIDX_W-1:0] bus_len,
    input logic              bus_last
);
    p_hold_payload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_data)
                                    && $stable(bus_strb) && $stable(bus_last));

    p_store_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> !st_ready);

    p_load_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && ld_valid && (ld_addr[ADDR_W-1:OFF_W] == bus_addr[ADDR_W-1:OFF_W])
        |-> !ld_ready);

    p_single_beat_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && (bus_len == '0) |-> bus_last &&
        ((bus_strb == 8'h0F) || (bus_strb == 8'hF0) || (bus_strb == 8'hFF)));

    p_burst_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && (bus_len != '0) |-> (bus_strb == 8'hFF));

    p_last_ends_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_ready && bus_last && (bus_len != '0) |=> !bus_valid);
endmodule

bind sgu_top sgu_checks #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .BIDX_W(BIDX_W)) u_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_ready (st_ready),
    .ld_valid (ld_valid),
    .ld_addr  (ld_addr),
    .ld_ready (ld_ready),
    .bus_valid(bus_valid),
    .bus_ready(bus_ready),
    .bus_addr (bus_addr),
    .bus_data (bus_data),
    .bus_strb (bus_strb),
    .bus_len  (bus_len),
    .bus_last (bus_last)
);

// File: tb/sgu_top_test.sv
module sgu_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic        st_ready;
    logic [31:0] st_addr = '0;
    logic [31:0] st_data = '0;
    logic        ld_valid = 1'b0;
    logic [31:0] ld_addr = '0;
    logic        ld_ready;
    logic        sync_req = 1'b0, nudge_req = 1'b0, exc_req = 1'b0;
    logic        bus_valid;
    logic        bus_ready = 1'b1;
    logic [31:0] bus_addr;
    logic [63:0] bus_data;
    logic [7:0]  bus_strb;
    logic [1:0]  bus_len;
    logic        bus_last;

    always #2 clk = ~clk;

    sgu_top uut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_ready(ld_ready),
        .sync_req(sync_req), .nudge_req(nudge_req), .exc_req(exc_req),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_strb(bus_strb), .bus_len(bus_len), .bus_last(bus_last)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [63:0] d;
        logic [7:0]  s;
        logic [1:0]  len;
        logic        last;
    } beat_t;

    beat_t exp_q[$];
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rdy_mode = 0;

    logic [26:0] m_tag;
    logic [31:0] m_w [8];
    logic [7:0]  m_mask = '0;
    logic        m_occ = 1'b0;

    task automatic chk(input logic ok, input string req, input logic [127:0] act,
                       input logic [127:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic summary_and_end();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        #1 bus_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            summary_and_end();
        end
    end

    // Monitor: scoreboard pop and handshake-hold checks (R8)
    beat_t held;
    logic  was_stalled = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (was_stalled)
                chk(bus_valid && bus_addr == held.a && bus_data == held.d &&
                    bus_strb == held.s && bus_last == held.last,
                    "R8 hold", {bus_addr, bus_data, bus_strb}, {held.a, held.d, held.s});
            if (bus_valid && st_ready)
                chk(1'b0, "R8 store port open during write-out", 1, 0);
            if (bus_valid && bus_ready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2/R5 unexpected beat", bus_addr, 0);
                end else begin
                    beat_t e;
                    e = exp_q.pop_front();
                    chk(bus_addr == e.a && bus_data == e.d && bus_strb == e.s &&
                        bus_len == e.len && bus_last == e.last, "R3/R7 beat",
                        {bus_addr, bus_data, bus_strb, bus_len, bus_last},
                        {e.a, e.d, e.s, e.len, e.last});
                end
            end
            was_stalled = bus_valid && !bus_ready;
            held = '{a: bus_addr, d: bus_data, s: bus_strb, len: bus_len, last: bus_last};
        end
    end

    task automatic flush_model();
        logic [31:0] base;
        base = {m_tag, 5'b0};
        if (m_mask == 8'hFF) begin
            for (int b = 0; b < 4; b++)
                exp_q.push_back('{a: base, d: {m_w[2*b+1], m_w[2*b]}, s: 8'hFF,
                                  len: 2'd3, last: (b == 3)});
        end else begin
            for (int b = 0; b < 4; b++) begin
                logic [1:0] p;
                p = m_mask[2*b +: 2];
                if (p != 2'b00)
                    exp_q.push_back('{a: base + 32'(8*b),
                                      d: {p[1] ? m_w[2*b+1] : 32'h0, p[0] ? m_w[2*b] : 32'h0},
                                      s: {{4{p[1]}}, {4{p[0]}}}, len: 2'd0, last: 1'b1});
            end
        end
        m_occ = 1'b0;
        m_mask = '0;
    endtask

    task automatic do_store(input logic [26:0] tag, input int idx, input logic [31:0] d,
                            output int stalls);
        if (m_occ && m_tag != tag) flush_model();
        if (!m_occ) begin
            m_occ = 1'b1;
            m_tag = tag;
            m_mask = '0;
        end
        m_w[idx] = d;
        m_mask[idx] = 1'b1;
        if (idx == 7) flush_model();
        stalls = 0;
        @(negedge clk);
        st_valid = 1'b1;
        st_addr = {tag, 3'(idx), 2'b00};
        st_data = d;
        #1;
        while (!st_ready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1 st_valid = 1'b0;
    endtask

    task automatic fill(input logic [26:0] tag, input int first, input int lastw);
        int s;
        for (int i = first; i <= lastw; i++) do_store(tag, i, {tag[15:0], 16'(i) ^ 16'hA5A0}, s);
    endtask

    task automatic pulse(input int which);
        if (m_occ) flush_model();
        @(negedge clk);
        if (which == 0) sync_req = 1'b1;
        else if (which == 1) nudge_req = 1'b1;
        else exc_req = 1'b1;
        @(posedge clk);
        #1;
        sync_req = 1'b0;
        nudge_req = 1'b0;
        exc_req = 1'b0;
    endtask

    task automatic drain(input string req);
        int n = 0;
        while ((exp_q.size() != 0 || bus_valid) && n < 300) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0 && !bus_valid, req, exp_q.size(), 0);
    endtask

    initial begin
        int s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!bus_valid && st_ready && ld_ready, "R1 reset outputs",
            {bus_valid, st_ready, ld_ready}, 3'b011);

        // R2 then R3: full line, gathered then one burst
        fill(27'h0000100, 0, 6);
        repeat (4) @(negedge clk);
        chk(!bus_valid && exp_q.size() == 0, "R2 no write before last word", bus_valid, 0);
        fill(27'h0000100, 7, 7);
        drain("R3 full burst drained");

        // R8: burst under back-pressure
        rdy_mode = 1;
        fill(27'h0000200, 0, 7);
        drain("R8 burst with stalls drained");

        // R5 + R7: sync on three words
        fill(27'h0000300, 0, 2);
        pulse(0);
        drain("R5 sync flush / R7 partial");

        // R5: nudge on five words
        rdy_mode = 0;
        fill(27'h0000400, 0, 4);
        pulse(1);
        drain("R5 nudge flush");

        // R5 + R7: exception, empty beat 0 skipped
        fill(27'h0000500, 2, 3);
        pulse(2);
        drain("R5 exception flush / R7 skip empty beat");

        // R5: pulses on empty buffer do nothing
        pulse(0);
        pulse(1);
        pulse(2);
        repeat (6) @(negedge clk);
        chk(!bus_valid && exp_q.size() == 0, "R5 pulses ignored when empty", bus_valid, 0);

        // R4: store to another line forces the held line out
        rdy_mode = 1;
        fill(27'h0000600, 0, 3);
        do_store(27'h0000700, 0, 32'h7777_0000, s);
        chk(s > 0, "R4 new-line store stalled", s, 1);
        fill(27'h0000700, 1, 7);
        drain("R4 both lines written in order");

        // R6: loads
        rdy_mode = 0;
        fill(27'h0000800, 0, 2);
        @(negedge clk);
        ld_valid = 1'b1;
        ld_addr = {27'h0000900, 5'h04};
        #1;
        chk(ld_ready == 1'b1, "R6 other-line load ready", ld_ready, 1);
        repeat (3) @(negedge clk);
        chk(!bus_valid && exp_q.size() == 0, "R6 other-line load no flush", bus_valid, 0);
        flush_model();
        ld_addr = {27'h0000800, 5'h04};
        #1;
        chk(ld_ready == 1'b0, "R6 matching load held", ld_ready, 0);
        s = 0;
        while (!ld_ready && s < 100) begin
            @(negedge clk);
            #1;
            s++;
        end
        chk(ld_ready && exp_q.size() == 0, "R6 load released after write-out", exp_q.size(), 0);
        ld_valid = 1'b0;
        drain("R6 drained");

        // R9: last word alone
        fill(27'h0000A00, 7, 7);
        drain("R9 lone last word");

        summary_and_end();
    end
endmodule